// File: doc/BRIEF.md
# Handheld Console Memory Bus Decoder

This block sits between an 8-bit CPU with a 16-bit address bus and everything that CPU can reach. It routes each accepted read or write to one target: a boot ROM overlay, a cartridge port, video RAM, work RAM, object attribute RAM, or the joypad, timer and video-register ports. It also owns a few things locally: a small high RAM, an interrupt-enable register, the boot-overlay flag, and a view of the interrupt-flag register. The bits of that flag register belong to the peripherals that raise them.

External targets share one offset bus, one write-data bus and one write strobe. Each target gets its own select bit. Each target returns a byte on its own slice of a read-data bus, combinationally in the same cycle as its select. The decoder registers that byte into a one-entry response stage.

Requests use a valid/ready handshake. The decoder accepts a request when `req_valid` and `req_ready` are both high. `req_ready` is low only while a read response is waiting and `rsp_ready` is low, so a stalled consumer holds back new requests. A write completes when it is accepted and produces no response beat. A read produces exactly one response beat, one cycle after acceptance, held until `rsp_ready` is high.

Top module: `membus_decoder`

## Requirements
- R1: While the boot flag is set, reads of 0x0000–0x00FE select the boot target (select bit 0) with offset addr[7:0]. Every other address below 0x8000, and every write there, selects the cartridge target (bit 1) with the full address as offset.
- R2: A read of 0x00FE while the boot flag is set returns the boot byte. The same access clears the flag, so later reads of low addresses select the cartridge.
- R3: The boot flag is 1 after reset and never sets again until the next reset. A write of any value to 0xFF50 clears it. A read of 0xFF50 returns 0x01 while it is set and 0x00 once it is clear.
- R4: 0x8000–0x9FFF selects video RAM (bit 2) with offset addr & 0x1FFF. 0xA000–0xBFFF selects the cartridge (bit 1) with the full address.
- R5: 0xC000–0xFDFF selects work RAM (bit 3) with offset addr & 0x1FFF, so 0xE000–0xFDFF reaches the same offsets as 0xC000–0xDDFF.
- R6: 0xFE00–0xFEFF selects object attribute RAM (bit 4) with offset addr[7:0]. 0xFF80–0xFFFE is local high RAM: a read returns the last byte written to that address.
- R7: 0xFFFF is the interrupt-enable register. It reads 0x00 after reset and returns the last byte written.
- R8: A read of 0xFF0F returns bit 0 = vblank, bit 1 = LCD status, bit 2 = timer, bit 4 = joypad (from `irq_src` bits 0..3), with the other bits 0. An accepted write there pulses `irq_flag_we` for one cycle with `irq_flag_wdata` = {data[4], data[2:0]}.
- R9: 0xFF00 selects the joypad port (bit 5), 0xFF04–0xFF07 the timer port (bit 6), and 0xFF40–0xFF7F except 0xFF50 the video register port (bit 7). Each gets offset addr[7:0].
- R10: Any other 0xFF00–0xFF7F address is unmapped. Reads of it return 0x00, and writes to it assert no select, no `tgt_we` and no `irq_flag_we`.
- R11: `req_ready` = !rsp_valid || rsp_ready. An accepted read gives `rsp_valid` on the next cycle, and the data is held stable while `rsp_ready` is low. Writes give no response beat.
- R12: `irq_pending` equals the interrupt-enable register bits [4:0] ANDed with the 5-bit flag view of R8, at all times.
- R13: At most one select bit is high, and only in a cycle where a request is accepted. `tgt_we` is high exactly when a select is high for a write, and `tgt_wdata` carries the request data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | CPU address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_rdata | output | 8 | Registered read data |
| tgt_sel | output | 8 | One-hot target select: boot, cart, vram, wram, oam, joypad, timer, video regs |
| tgt_addr | output | 16 | Offset within the selected target |
| tgt_we | output | 1 | Write strobe for the selected target |
| tgt_wdata | output | 8 | Write data to targets |
| tgt_rdata | input | 64 | Read bytes, target i on bits [8i+7:8i] |
| irq_src | input | 4 | Flags owned by peripherals: vblank, LCD status, timer, joypad |
| irq_flag_we | output | 1 | Write pulse for the peripheral flags |
| irq_flag_wdata | output | 4 | New flag values, same order as irq_src |
| irq_pending | output | 5 | Enabled and raised interrupts |

## Verification
Some properties are checked by assertions on every cycle. These are the one-hot select that is raised only when a request is accepted, the read response that appears one cycle after a read is accepted and holds through a stall, the boot flag that cannot set again once clear, its clearing by the 0x00FE read, and the flag write pulse that is raised only for writes. The address map needs the bench's scenarios. The bench sweeps every address, checks each select, offset and read byte, and then sweeps the write side of the I/O page. Those scenarios are the only place to show the boot overlay's range and its exit, the masking of the mirrors, the unmapped holes, high RAM and IE retention, and the pending vector.

// File: rtl/membus_pkg.sv
package membus_pkg;
  // Routing result of one address. External targets come first so their
  // code is also their select bit index.
  typedef enum logic [3:0] {
    DST_BOOT    = 4'd0,
    DST_CART    = 4'd1,
    DST_VRAM    = 4'd2,
    DST_WRAM    = 4'd3,
    DST_OAM     = 4'd4,
    DST_JOY     = 4'd5,
    DST_TMR     = 4'd6,
    DST_VREG    = 4'd7,
    DST_HRAM    = 4'd8,
    DST_IE      = 4'd9,
    DST_IF      = 4'd10,
    DST_BOOTREG = 4'd11,
    DST_NONE    = 4'd12
  } dest_e;

  localparam int unsigned N_EXT = 8;
  localparam int unsigned N_IRQ_SRC = 4;
  localparam int unsigned N_IRQ_VEC = 5;
endpackage

// File: rtl/membus_addr_decode.sv
module membus_addr_decode
  import membus_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned WIN_AW = 13
) (
  input  logic [AW-1:0] addr,
  input  logic          is_write,
  input  logic          boot_on,
  output dest_e         dest,
  output logic [AW-1:0] offset
);
  localparam logic [AW-1:0] WIN_MASK = AW'((1 << WIN_AW) - 1);

  always_comb begin
    dest   = DST_NONE;
    offset = {{(AW-8){1'b0}}, addr[7:0]};
    if (!addr[15]) begin
      if (!is_write && boot_on && addr <= 16'h00FE) begin
        dest = DST_BOOT;
      end else begin
        dest   = DST_CART;
        offset = addr;
      end
    end else if (addr < 16'hA000) begin
      dest   = DST_VRAM;
      offset = addr & WIN_MASK;
    end else if (addr < 16'hC000) begin
      dest   = DST_CART;
      offset = addr;
    end else if (addr < 16'hFE00) begin
      dest   = DST_WRAM;
      offset = addr & WIN_MASK;
    end else if (addr[15:8] == 8'hFE) begin
      dest = DST_OAM;
    end else if (addr == 16'hFFFF) begin
      dest = DST_IE;
    end else if (addr[7]) begin
      dest   = DST_HRAM;
      offset = {{(AW-7){1'b0}}, addr[6:0]};
    end else if (addr[7:0] == 8'h00) begin
      dest = DST_JOY;
    end else if (addr[7:2] == 6'b000001) begin
      dest = DST_TMR;
    end else if (addr[7:0] == 8'h0F) begin
      dest = DST_IF;
    end else if (addr[7:0] == 8'h50) begin
      dest = DST_BOOTREG;
    end else if (addr[7:6] == 2'b01) begin
      dest = DST_VREG;
    end
  end
endmodule

// File: rtl/membus_local_regs.sv
module membus_local_regs
  import membus_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned HRAM_AW = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc,
  input  logic                 is_write,
  input  dest_e                dest,
  input  logic [7:0]           addr_lo,
  input  logic [DW-1:0]        wdata,
  input  logic [N_IRQ_SRC-1:0] irq_src,
  output logic                 boot_on,
  output logic [DW-1:0]        rdata,
  output logic                 irq_flag_we,
  output logic [N_IRQ_SRC-1:0] irq_flag_wdata,
  output logic [N_IRQ_VEC-1:0] irq_pending
);
  localparam int unsigned HRAM_WORDS = 1 << HRAM_AW;

  logic [DW-1:0] hram [HRAM_WORDS];
  logic [DW-1:0] ie_q;
  logic          boot_q;
  logic [N_IRQ_VEC-1:0] if_view;
  logic          boot_exit_rd;
  logic          boot_exit_wr;

  assign if_view = {irq_src[3], 1'b0, irq_src[2:0]};
  assign boot_exit_rd = acc && !is_write && dest == DST_BOOT && addr_lo == 8'hFE;
  assign boot_exit_wr = acc && is_write && dest == DST_BOOTREG;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_q <= 1'b1;
      ie_q   <= '0;
    end else begin
      if (boot_exit_rd || boot_exit_wr) boot_q <= 1'b0;
      if (acc && is_write && dest == DST_IE) ie_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (acc && is_write && dest == DST_HRAM) hram[addr_lo[HRAM_AW-1:0]] <= wdata;
  end

  always_comb begin
    rdata = '0;
    case (dest)
      DST_HRAM:    rdata = hram[addr_lo[HRAM_AW-1:0]];
      DST_IE:      rdata = ie_q;
      DST_IF:      rdata = DW'(if_view);
      DST_BOOTREG: rdata = DW'(boot_q);
      default:     rdata = '0;
    endcase
  end

  assign boot_on        = boot_q;
  assign irq_flag_we    = acc && is_write && dest == DST_IF;
  assign irq_flag_wdata = {wdata[4], wdata[2:0]};
  assign irq_pending    = ie_q[N_IRQ_VEC-1:0] & if_view;

  // R3: once cleared, the overlay flag stays clear until reset
  assert_boot_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_q |=> !boot_q);
  // R2: the exit read leaves the overlay off on the next cycle
  assert_boot_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !is_write && dest == DST_BOOT && addr_lo == 8'hFE) |=> !boot_q);
  // R8: the flag write pulse only ever comes from a write
  assert_flag_we_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flag_we |-> (acc && is_write));
endmodule

// File: rtl/membus_decoder.sv
module membus_decoder
  import membus_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [AW-1:0]          req_addr,
  input  logic [DW-1:0]          req_wdata,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [DW-1:0]          rsp_rdata,
  output logic [N_EXT-1:0]       tgt_sel,
  output logic [AW-1:0]          tgt_addr,
  output logic                   tgt_we,
  output logic [DW-1:0]          tgt_wdata,
  input  logic [N_EXT*DW-1:0]    tgt_rdata,
  input  logic [N_IRQ_SRC-1:0]   irq_src,
  output logic                   irq_flag_we,
  output logic [N_IRQ_SRC-1:0]   irq_flag_wdata,
  output logic [N_IRQ_VEC-1:0]   irq_pending
);
  dest_e         dest;
  logic [AW-1:0] offset;
  logic          fire;
  logic          boot_on;
  logic [DW-1:0] local_rdata;
  logic [DW-1:0] ext_bytes [N_EXT];
  logic [DW-1:0] pick_rdata;
  logic          rsp_valid_q;
  logic [DW-1:0] rsp_rdata_q;

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign fire      = req_valid && req_ready;

  membus_addr_decode #(.AW(AW)) u_dec (
    .addr     (req_addr),
    .is_write (req_write),
    .boot_on  (boot_on),
    .dest     (dest),
    .offset   (offset)
  );

  membus_local_regs #(.DW(DW)) u_loc (
    .clk            (clk),
    .rst_n          (rst_n),
    .acc            (fire),
    .is_write       (req_write),
    .dest           (dest),
    .addr_lo        (req_addr[7:0]),
    .wdata          (req_wdata),
    .irq_src        (irq_src),
    .boot_on        (boot_on),
    .rdata          (local_rdata),
    .irq_flag_we    (irq_flag_we),
    .irq_flag_wdata (irq_flag_wdata),
    .irq_pending    (irq_pending)
  );

  for (genvar gi = 0; gi < N_EXT; gi++) begin : g_ext
    assign tgt_sel[gi]   = fire && (dest == dest_e'(gi));
    assign ext_bytes[gi] = tgt_rdata[gi*DW +: DW];
  end

  assign tgt_addr  = offset;
  assign tgt_wdata = req_wdata;
  assign tgt_we    = req_write && (|tgt_sel);

  always_comb begin
    if (int'(dest) < N_EXT) pick_rdata = ext_bytes[dest[2:0]];
    else                    pick_rdata = local_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else if (fire && !req_write) begin
      rsp_valid_q <= 1'b1;
      rsp_rdata_q <= pick_rdata;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;

  // R13: never more than one target addressed
  assert_sel_onehot_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_sel));
  // R13: no target is touched without an accepted request
  assert_sel_needs_accept_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |-> (tgt_sel == '0));
  // R11: an accepted read yields a response on the next cycle
  assert_read_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);
  // R11: a stalled response keeps its data
  assert_resp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
endmodule

// File: tb/membus_decoder_bench.sv
`timescale 1ns/1ps
module membus_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [7:0]  rsp_rdata;
  logic [7:0]  tgt_sel;
  logic [15:0] tgt_addr;
  logic        tgt_we;
  logic [7:0]  tgt_wdata;
  logic [63:0] tgt_rdata;
  logic [3:0]  irq_src = 4'b1011;
  logic        irq_flag_we;
  logic [3:0]  irq_flag_wdata;
  logic [4:0]  irq_pending;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] m_hram [128];
  logic [7:0] m_ie;
  bit         m_boot;

  always #2.5 clk = ~clk;

  membus_decoder u_membus_decoder (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .tgt_sel(tgt_sel), .tgt_addr(tgt_addr), .tgt_we(tgt_we), .tgt_wdata(tgt_wdata),
    .tgt_rdata(tgt_rdata), .irq_src(irq_src),
    .irq_flag_we(irq_flag_we), .irq_flag_wdata(irq_flag_wdata),
    .irq_pending(irq_pending)
  );

  function automatic logic [7:0] ext_val(int i, logic [15:0] off);
    return 8'(8'h11 * i + 8'h07) ^ off[7:0] ^ off[15:8];
  endfunction

  for (genvar gi = 0; gi < 8; gi++) begin : g_tgt
    assign tgt_rdata[gi*8 +: 8] = ext_val(gi, tgt_addr);
  end

  // 0..7 external select bit, 8 hram, 9 ie, 10 if, 11 boot reg, 12 unmapped
  function automatic int exp_code(logic [15:0] a, bit wr, bit boot);
    if (a < 16'h8000) return (!wr && boot && a <= 16'h00FE) ? 0 : 1;
    if (a < 16'hA000) return 2;
    if (a < 16'hC000) return 1;
    if (a < 16'hFE00) return 3;
    if (a < 16'hFF00) return 4;
    if (a == 16'hFFFF) return 9;
    if (a >= 16'hFF80) return 8;
    if (a == 16'hFF00) return 5;
    if (a >= 16'hFF04 && a <= 16'hFF07) return 6;
    if (a == 16'hFF0F) return 10;
    if (a == 16'hFF50) return 11;
    if (a >= 16'hFF40 && a <= 16'hFF7F) return 7;
    return 12;
  endfunction

  function automatic logic [15:0] exp_off(logic [15:0] a, int c);
    if (c == 1) return a;
    if (c == 2 || c == 3) return {3'b000, a[12:0]};
    return {8'h00, a[7:0]};
  endfunction

  function automatic string req_of(int c);
    case (c)
      0: return "R1";
      1: return "R1/R4";
      2: return "R4";
      3: return "R5";
      4, 8: return "R6";
      5, 6, 7: return "R9";
      9: return "R7";
      10: return "R8";
      11: return "R3";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [7:0] if_val();
    return {3'b000, irq_src[3], 1'b0, irq_src[2:0]};
  endfunction

  task automatic check(bit ok, string rq, string what, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic bus_read(logic [15:0] a, string rq_override = "");
    int c;
    logic [15:0] off;
    logic [7:0] ev;
    logic [7:0] esel;
    string rq;
    @(negedge clk);
    c = exp_code(a, 1'b0, m_boot);
    off = exp_off(a, c);
    rq = (rq_override != "") ? rq_override : req_of(c);
    esel = (c < 8) ? 8'(1 << c) : 8'h00;
    case (c)
      8: ev = m_hram[a[6:0]];
      9: ev = m_ie;
      10: ev = if_val();
      11: ev = {7'd0, m_boot};
      12: ev = 8'h00;
      default: ev = ext_val(c, off);
    endcase
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    #1;
    check(tgt_sel == esel, rq, $sformatf("select @%04h", a), tgt_sel, esel);
    if (c < 8) check(tgt_addr == off, rq, $sformatf("offset @%04h", a), tgt_addr, off);
    if (c == 0 && a == 16'h00FE) m_boot = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == 1'b1, "R11", "read response valid", rsp_valid, 1);
    check(rsp_rdata == ev, rq, $sformatf("read data @%04h", a), rsp_rdata, ev);
  endtask

  task automatic bus_write(logic [15:0] a, logic [7:0] d);
    int c;
    logic [15:0] off;
    logic [7:0] esel;
    @(negedge clk);
    c = exp_code(a, 1'b1, m_boot);
    off = exp_off(a, c);
    esel = (c < 8) ? 8'(1 << c) : 8'h00;
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    #1;
    check(tgt_sel == esel, req_of(c), $sformatf("write select @%04h", a), tgt_sel, esel);
    check(tgt_we == (c < 8), "R13", $sformatf("write strobe @%04h", a), tgt_we, (c < 8));
    if (c < 8) begin
      check(tgt_addr == off, req_of(c), $sformatf("write offset @%04h", a), tgt_addr, off);
      check(tgt_wdata == d, "R13", "write data", tgt_wdata, d);
    end
    check(irq_flag_we == (c == 10), (c == 10) ? "R8" : "R10", $sformatf("flag pulse @%04h", a),
          irq_flag_we, (c == 10));
    if (c == 10)
      check(irq_flag_wdata == {d[4], d[2:0]}, "R8", "flag data", irq_flag_wdata, {d[4], d[2:0]});
    case (c)
      8: m_hram[a[6:0]] = d;
      9: m_ie = d;
      11: m_boot = 1'b0;
      default: ;
    endcase
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check(rsp_valid == 1'b0, "R11", "no response for write", rsp_valid, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_boot = 1'b1;
    m_ie = 8'h00;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    do_reset();
    #1;
    check(rsp_valid == 1'b0, "R11", "reset rsp_valid", rsp_valid, 0);
    check(req_ready == 1'b1, "R11", "reset req_ready", req_ready, 1);
    check(irq_pending == 5'd0, "R12", "reset pending", irq_pending, 0);
    bus_read(16'hFF50);                    // R3 reads 01 after reset
    bus_read(16'hFFFF);                    // R7 reads 00 after reset

    for (int a = 0; a < 16'h00FE; a++) bus_read(16'(a));   // R1 overlay range
    bus_read(16'h00FF);                    // R1 just above overlay
    bus_read(16'h0100);
    bus_write(16'h0010, 8'h5A);            // R1 writes go to cartridge
    bus_read(16'h00FE, "R2");              // R2 exit read returns boot byte
    bus_read(16'hFF50, "R3");              // flag now 00
    bus_read(16'h0000, "R2");              // cartridge after exit
    bus_read(16'h00FE, "R2");

    do_reset();
    bus_read(16'h0020, "R3");              // overlay back after reset
    bus_write(16'hFF50, 8'h00);            // R3 any value clears
    bus_read(16'hFF50, "R3");
    bus_read(16'h0020, "R3");

    for (int a = 16'hFF80; a <= 16'hFFFE; a++) bus_write(16'(a), 8'(a) ^ 8'hA5);  // R6 fill

    bus_write(16'hFFFF, 8'h1F);
    #1 check(irq_pending == (5'h1F & if_val()), "R12", "pending all enabled", irq_pending, 5'h1F & if_val());
    bus_write(16'hFFFF, 8'h06);
    #1 check(irq_pending == (5'h06 & if_val()), "R12", "pending partial", irq_pending, 5'h06 & if_val());
    irq_src = 4'b1100;
    #1 check(irq_pending == (5'h06 & if_val()), "R12", "pending after source change", irq_pending, 5'h06 & if_val());
    bus_write(16'hFF0F, 8'h15);            // R8 flag write
    bus_write(16'hFF0F, 8'hEA);

    bus_write(16'h8000, 8'h01); bus_write(16'h9FFF, 8'h02);
    bus_write(16'hA000, 8'h03); bus_write(16'hC000, 8'h04);
    bus_write(16'hE123, 8'h05); bus_write(16'hFDFF, 8'h06);
    bus_write(16'hFE9F, 8'h07); bus_write(16'h7FFF, 8'h08);

    for (int a = 16'hFF00; a <= 16'hFFFF; a++) bus_write(16'(a), 8'(a) ^ 8'h3C);  // I/O page writes
    #1 check(irq_pending == (m_ie[4:0] & if_val()), "R12", "pending after sweep", irq_pending, m_ie[4:0] & if_val());

    for (int a = 0; a <= 16'hFFFF; a++) bus_read(16'(a));   // full read map, overlay off

    // R11 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'hFFFF;
    @(negedge clk);
    check(rsp_valid == 1'b1 && rsp_rdata == m_ie, "R11", "stalled first beat", rsp_rdata, m_ie);
    req_addr = 16'h8005;
    #1;
    check(req_ready == 1'b0, "R11", "ready low while stalled", req_ready, 0);
    check(tgt_sel == 8'h00, "R11", "no select while stalled", tgt_sel, 0);
    @(negedge clk);
    check(rsp_valid == 1'b1 && rsp_rdata == m_ie, "R11", "data held in stall", rsp_rdata, m_ie);
    rsp_ready = 1'b1;
    #1;
    check(req_ready == 1'b1, "R11", "ready returns", req_ready, 1);
    check(tgt_sel == 8'h04, "R11", "pending request accepted", tgt_sel, 8'h04);
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_rdata == ext_val(2, 16'h0005), "R11", "second beat data", rsp_rdata, ext_val(2, 16'h0005));
    @(negedge clk);
    check(rsp_valid == 1'b0, "R11", "response drained", rsp_valid, 0);

    summary();
  end
endmodule